// File: doc/BRIEF.md
# Signed Magnitude Comparator by Subtraction

This block compares two two's complement operands and raises exactly one of three flags: greater, less or equal. It has no clock and no state. The outputs follow the inputs through combinational logic only.

The comparison is done by subtraction. The B operand passes through a row of XOR gates that invert it. A single ripple-carry adder then adds A, the inverted B and a carry-in fixed at 1, which gives A minus B. The equal flag comes from a zero test on the difference. The less flag is the sign bit of the difference, corrected by the signed overflow term. The greater flag is high whenever neither of the other two is high.

There are no cascading inputs. The operand width is a parameter with a default of 4, which covers the values -8 to +7.

Top module: `signed_sub_compare`

## Requirements
- R1: `eq_o` is 1 exactly when `a_in` and `b_in` hold the same bit pattern, and 0 otherwise.
- R2: `lt_o` is 1 exactly when `a_in` is less than `b_in`, with both read as two's complement signed values.
- R3: `gt_o` is 1 exactly when `a_in` is greater than `b_in`, with both read as two's complement signed values.
- R4: For every operand pair, exactly one of `gt_o`, `lt_o` and `eq_o` is 1.
- R5: With the default width, `a_in`=4'b1000 (-8) and `b_in`=4'b0111 (+7) give `lt_o`=1, even though the subtraction overflows.
- R6: With the default width, `a_in`=4'b0111 (+7) and `b_in`=4'b1000 (-8) give `gt_o`=1, even though the subtraction overflows.
- R7: The outputs settle after an input change without any clock edge. The block holds no state.
- R8: The most negative value compared with itself (4'b1000 against 4'b1000) gives `eq_o`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | WIDTH | Operand A, two's complement |
| b_in | input | WIDTH | Operand B, two's complement |
| gt_o | output | 1 | A is greater than B |
| lt_o | output | 1 | A is less than B |
| eq_o | output | 1 | A equals B |

## Verification
The bench builds one instance with WIDTH=4. At that width all 256 operand pairs can be walked exhaustively, so both overflow corners and the most-negative self-compare are covered directly. A second instance with WIDTH=8 receives seeded random pairs mixed with directed extremes. This shows that the overflow correction holds when the carry chain is longer.

// File: rtl/sgncmp_pkg.sv
package sgncmp_pkg;
  localparam int unsigned SGNCMP_DEF_WIDTH = 4;

  typedef enum logic [2:0] {
    CMP_GT = 3'b100,
    CMP_LT = 3'b010,
    CMP_EQ = 3'b001
  } cmp_flags_e;
endpackage

// File: rtl/sgncmp_invert.sv
module sgncmp_invert #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             inv_en,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_xor
      assign d_out[gi] = d_in[gi] ^ inv_en;
    end
  endgenerate
endmodule

// File: rtl/sgncmp_ripple_adder.sv
module sgncmp_ripple_adder #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             c_into_msb,
  output logic             cout
);
  logic [WIDTH:0] carry;

  assign carry[0] = cin;

  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_fa
      assign sum[gi]      = op_a[gi] ^ op_b[gi] ^ carry[gi];
      assign carry[gi+1]  = (op_a[gi] & op_b[gi]) | (carry[gi] & (op_a[gi] ^ op_b[gi]));
    end
  endgenerate

  assign c_into_msb = carry[WIDTH-1];
  assign cout       = carry[WIDTH];

  // Ripple chain agrees with arithmetic addition (supports R2, R3)
  always_comb begin
    assert_adder_sum_R2: assert ({cout, sum} == ({1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, cin}))
      else $error("ripple adder result mismatch");
  end
endmodule

// File: rtl/sgncmp_flag_decode.sv
module sgncmp_flag_decode #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] diff,
  input  logic             c_into_msb,
  input  logic             cout,
  output logic             gt,
  output logic             lt,
  output logic             eq
);
  logic ovf;

  assign ovf = c_into_msb ^ cout;
  assign lt  = diff[WIDTH-1] ^ ovf;
  assign eq  = ~|diff;
  assign gt  = ~lt & ~eq;

  // Flags never collide (R4)
  always_comb begin
    assert_one_flag_R4: assert ($onehot({gt, lt, eq}))
      else $error("flags not one-hot");
  end
endmodule

// File: rtl/signed_sub_compare.sv
module signed_sub_compare #(
  parameter int unsigned WIDTH = sgncmp_pkg::SGNCMP_DEF_WIDTH
) (
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  output logic             gt_o,
  output logic             lt_o,
  output logic             eq_o
);
  localparam logic SUB_MODE = 1'b1;

  logic [WIDTH-1:0] b_inv;
  logic [WIDTH-1:0] diff;
  logic             c_msb;
  logic             c_out;

  sgncmp_invert #(.WIDTH(WIDTH)) u_invert (
    .inv_en (SUB_MODE),
    .d_in   (b_in),
    .d_out  (b_inv)
  );

  sgncmp_ripple_adder #(.WIDTH(WIDTH)) u_adder (
    .op_a       (a_in),
    .op_b       (b_inv),
    .cin        (SUB_MODE),
    .sum        (diff),
    .c_into_msb (c_msb),
    .cout       (c_out)
  );

  sgncmp_flag_decode #(.WIDTH(WIDTH)) u_decode (
    .diff       (diff),
    .c_into_msb (c_msb),
    .cout       (c_out),
    .gt         (gt_o),
    .lt         (lt_o),
    .eq         (eq_o)
  );

  // Port-level relations to signed arithmetic
  always_comb begin
    assert_equal_flag_R1: assert (eq_o == (a_in == b_in))
      else $error("equal flag wrong");
    assert_less_flag_R2: assert (lt_o == ($signed(a_in) < $signed(b_in)))
      else $error("less flag wrong");
    assert_greater_flag_R3: assert (gt_o == ($signed(a_in) > $signed(b_in)))
      else $error("greater flag wrong");
  end
endmodule

// File: tb/signed_sub_compare_bench.sv
module signed_sub_compare_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  logic [3:0] a4, b4;
  logic       gt4, lt4, eq4;
  logic [7:0] a8, b8;
  logic       gt8, lt8, eq8;

  signed_sub_compare #(.WIDTH(4)) u_signed_sub_compare (
    .a_in(a4), .b_in(b4), .gt_o(gt4), .lt_o(lt4), .eq_o(eq4)
  );

  signed_sub_compare #(.WIDTH(8)) u_signed_sub_compare_w8 (
    .a_in(a8), .b_in(b8), .gt_o(gt8), .lt_o(lt8), .eq_o(eq8)
  );

  function automatic logic [2:0] ref4(input logic [3:0] a, input logic [3:0] b);
    int sa = $signed(a);
    int sb = $signed(b);
    return {sa > sb, sa < sb, sa == sb};
  endfunction

  function automatic logic [2:0] ref8(input logic [7:0] a, input logic [7:0] b);
    int sa = $signed(a);
    int sb = $signed(b);
    return {sa > sb, sa < sb, sa == sb};
  endfunction

  function automatic string tag_of(input logic [2:0] e);
    if (e[2]) return "R3";
    if (e[1]) return "R2";
    return "R1";
  endfunction

  task automatic check(input logic [2:0] got, input logic [2:0] exp, input string req);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: got gt/lt/eq=%b expected %b", req, got, exp);
    end
  endtask

  task automatic apply4(input logic [3:0] a, input logic [3:0] b);
    @(negedge clk);
    a4 = a; b4 = b;
    #2;
  endtask

  task automatic apply8(input logic [7:0] a, input logic [7:0] b);
    @(negedge clk);
    a8 = a; b8 = b;
    #2;
  endtask

  initial begin
    int unsigned r;
    a4 = '0; b4 = '0; a8 = '0; b8 = '0;
    r = $urandom(32'd1234);
    @(negedge clk); #2;
    check({gt4, lt4, eq4}, 3'b001, "R1 idle zero");

    // R7: change inputs with no clock edge in between
    @(negedge clk);
    a4 = 4'd3; b4 = 4'd1; #1;
    check({gt4, lt4, eq4}, 3'b100, "R7 no-clock settle gt");
    b4 = 4'd5; #1;
    check({gt4, lt4, eq4}, 3'b010, "R7 no-clock settle lt");

    apply4(4'b1000, 4'b0111);
    check({gt4, lt4, eq4}, 3'b010, "R5 -8 vs +7");
    apply4(4'b0111, 4'b1000);
    check({gt4, lt4, eq4}, 3'b100, "R6 +7 vs -8");
    apply4(4'b1000, 4'b1000);
    check({gt4, lt4, eq4}, 3'b001, "R8 -8 vs -8");

    // Exhaustive sweep at width 4
    for (int i = 0; i < 256; i++) begin
      logic [2:0] e;
      logic [7:0] iv;
      iv = i[7:0];
      apply4(iv[7:4], iv[3:0]);
      e = ref4(iv[7:4], iv[3:0]);
      check({gt4, lt4, eq4}, e, tag_of(e));
      n_checks++;
      if ($countones({gt4, lt4, eq4}) != 1) begin
        n_fails++;
        $display("FAIL R4: got %b expected one-hot", {gt4, lt4, eq4});
      end
    end

    // Width 8: directed extremes then seeded random
    apply8(8'h80, 8'h7F);
    check({gt8, lt8, eq8}, 3'b010, "R2 w8 min vs max");
    apply8(8'h7F, 8'h80);
    check({gt8, lt8, eq8}, 3'b100, "R3 w8 max vs min");
    apply8(8'h80, 8'h80);
    check({gt8, lt8, eq8}, 3'b001, "R1 w8 min equal");
    for (int k = 0; k < 300; k++) begin
      logic [2:0] e;
      logic [7:0] ra, rb;
      ra = $urandom();
      rb = (k % 8 == 0) ? ra : 8'($urandom());
      apply8(ra, rb);
      e = ref8(ra, rb);
      check({gt8, lt8, eq8}, e, tag_of(e));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end
endmodule